// File: doc/BRIEF.md
# USB Host Port Connection State Controller

This block follows the attachment status of one USB host port. It watches the two data line levels, the host role request and the start-of-frame enable bit, and keeps the port in one of four states: Reset, Idle, Ready or Suspend. It reports the current state and emits one-cycle event pulses when a device attaches or detaches. It drives a VBUS power enable and produces a periodic frame-start strobe while the port is active.

The data line levels pass through a debounce filter before the state machine uses them. The port counts as attached when either line is high, and as detached when both lines are low. A device can only be seen if the host supplies VBUS, so attachment is accepted only while the VBUS request bit is set. The start-of-frame enable bit is the only way into and out of Suspend. Leaving host role, either by clearing the enable or by raising the role input, returns the port to Reset from any state.

Top module: `usb_host_conn_ctrl`

## Requirements
- R1: While `rst_n` is low and on release, `state_o` is 0 (Reset) and every other output is 0.
- R2: In Reset, with `ctl_en`=1 and `id_level`=0 at a clock edge, the state becomes Idle at that edge.
- R3: At any edge where `ctl_en`=0 or `id_level`=1, the state becomes Reset. This takes priority over every other transition and raises no event pulse.
- R4: The line condition (`dp_in` OR `dm_in`) counts only after it has differed from the accepted value on DEBOUNCE_CYCLES consecutive edges (default 4). A shorter glitch leaves the state unchanged.
- R5: In Idle, with the filtered lines showing attach and `vbus_req`=1, the next state is Ready. Without `vbus_req` the port stays in Idle.
- R6: In Ready, `sof_en`=0 moves the port to Suspend. In Suspend, `sof_en`=1 moves it back to Ready.
- R7: In Ready or Suspend, a filtered detach (both lines low) moves the port to Idle. This takes priority over the `sof_en` transitions.
- R8: `connect_pulse_o` is high for exactly the one cycle after an Idle-to-Ready edge. `disconnect_pulse_o` is high for exactly the one cycle after an R7 return to Idle.
- R9: `vbus_en_o` equals `vbus_req` AND `ctl_en` AND NOT `id_level`, registered one edge later.
- R10: While the port stays in Ready, `frame_strobe_o` pulses for one cycle every FRAME_CYCLES cycles. The first pulse comes FRAME_CYCLES cycles after entry to Ready. The strobe is never high outside Ready.
- R11: `state_o` encodes Reset=0, Idle=1, Ready=2, Suspend=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable |
| id_level | input | 1 | Role input, 0 selects host |
| vbus_req | input | 1 | VBUS power request |
| dp_in | input | 1 | Sampled D+ level |
| dm_in | input | 1 | Sampled D- level |
| sof_en | input | 1 | Start-of-frame generation enable |
| state_o | output | 2 | Current port state |
| vbus_en_o | output | 1 | VBUS power enable |
| connect_pulse_o | output | 1 | Device attach event |
| disconnect_pulse_o | output | 1 | Device detach event |
| frame_strobe_o | output | 1 | Frame-start strobe |

## Verification
State changes and event pulses appear one edge after the deciding inputs. A line change reaches the state DEBOUNCE_CYCLES+1 edges after it is applied. `vbus_en_o` follows its inputs after one edge. The frame strobe comes FRAME_CYCLES edges after Ready is entered. The bench drives inputs on the falling edge and steps a cycle model at the rising edge. It then compares every output at the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/usb_hc_pkg.sv
package usb_hc_pkg;
    typedef enum logic [1:0] {
        PORT_RESET   = 2'd0,
        PORT_IDLE    = 2'd1,
        PORT_READY   = 2'd2,
        PORT_SUSPEND = 2'd3
    } port_state_e;
endpackage

// File: rtl/usb_hc_line_filter.sv
module usb_hc_line_filter #(
    parameter int DEBOUNCE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             filt;
    } flt_t;

    flt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (raw_i == r_q.filt) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.filt = raw_i;
            r_d.cnt  = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign filt_o = r_q.filt;

    // R4: the accepted level cannot move before the full run of differing samples
    p_filter_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i != r_q.filt && r_q.cnt != LAST) |=> (r_q.filt == $past(r_q.filt)));
    // R4: a matching sample never changes the accepted level
    p_filter_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == r_q.filt) |=> $stable(r_q.filt));
endmodule

// File: rtl/usb_hc_frame_timer.sv
module usb_hc_frame_timer #(
    parameter int FRAME_CYCLES = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_o
);
    localparam int CNT_W = $clog2(FRAME_CYCLES + 1);
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(FRAME_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.strobe = 1'b0;
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == WRAP) begin
            r_d.cnt    = '0;
            r_d.strobe = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign strobe_o = r_q.strobe;

    // R10: a stopped timer never emits a strobe in the following cycle
    p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !r_q.strobe);
    // R10: consecutive strobes are impossible with a period above one
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.strobe && FRAME_CYCLES > 1) |=> !r_q.strobe);
endmodule

// File: rtl/usb_hc_conn_fsm.sv
module usb_hc_conn_fsm
    import usb_hc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_en,
    input  logic        id_level,
    input  logic        vbus_req,
    input  logic        attached_i,
    input  logic        sof_en,
    output port_state_e state_o,
    output logic        vbus_en_o,
    output logic        connect_o,
    output logic        disconnect_o
);
    typedef struct packed {
        port_state_e st;
        logic        vbus;
        logic        conn;
        logic        disc;
    } fsm_t;

    fsm_t r_d, r_q;
    logic host_ok;

    assign host_ok = ctl_en & ~id_level;

    always_comb begin
        r_d      = r_q;
        r_d.conn = 1'b0;
        r_d.disc = 1'b0;
        r_d.vbus = vbus_req & host_ok;
        if (!host_ok) begin
            r_d.st = PORT_RESET;
        end else begin
            unique case (r_q.st)
                PORT_RESET: r_d.st = PORT_IDLE;
                PORT_IDLE: begin
                    if (attached_i && vbus_req) begin
                        r_d.st   = PORT_READY;
                        r_d.conn = 1'b1;
                    end
                end
                PORT_READY: begin
                    if (!attached_i) begin
                        r_d.st   = PORT_IDLE;
                        r_d.disc = 1'b1;
                    end else if (!sof_en) begin
                        r_d.st = PORT_SUSPEND;
                    end
                end
                PORT_SUSPEND: begin
                    if (!attached_i) begin
                        r_d.st   = PORT_IDLE;
                        r_d.disc = 1'b1;
                    end else if (sof_en) begin
                        r_d.st = PORT_READY;
                    end
                end
                default: r_d.st = PORT_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PORT_RESET, vbus: 1'b0, conn: 1'b0, disc: 1'b0};
        else        r_q <= r_d;
    end

    assign state_o      = r_q.st;
    assign vbus_en_o    = r_q.vbus;
    assign connect_o    = r_q.conn;
    assign disconnect_o = r_q.disc;

    // R3: leaving host role always lands in Reset
    p_host_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ok |=> (r_q.st == PORT_RESET && !r_q.conn && !r_q.disc));
    // R8: a connect event only accompanies an Idle-to-Ready move
    p_connect_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.conn |-> (r_q.st == PORT_READY && $past(r_q.st) == PORT_IDLE));
    // R8: a disconnect event only accompanies a return to Idle
    p_disconnect_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.disc |-> (r_q.st == PORT_IDLE && $past(r_q.st) != PORT_IDLE));
    // R6: resuming frame generation leaves Suspend while attached
    p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PORT_SUSPEND && host_ok && attached_i && sof_en) |=> (r_q.st == PORT_READY));
    // R7: detach from a connected state returns to Idle
    p_detach_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == PORT_READY || r_q.st == PORT_SUSPEND) && host_ok && !attached_i)
        |=> (r_q.st == PORT_IDLE));
endmodule

// File: rtl/usb_host_conn_ctrl.sv
module usb_host_conn_ctrl
    import usb_hc_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 4,
    parameter int FRAME_CYCLES    = 48000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_en,
    input  logic       id_level,
    input  logic       vbus_req,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic       sof_en,
    output logic [1:0] state_o,
    output logic       vbus_en_o,
    output logic       connect_pulse_o,
    output logic       disconnect_pulse_o,
    output logic       frame_strobe_o
);
    logic        attached;
    logic        tick;
    port_state_e cur_state;

    usb_hc_line_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (dp_in | dm_in),
        .filt_o (attached)
    );

    usb_hc_conn_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_en       (ctl_en),
        .id_level     (id_level),
        .vbus_req     (vbus_req),
        .attached_i   (attached),
        .sof_en       (sof_en),
        .state_o      (cur_state),
        .vbus_en_o    (vbus_en_o),
        .connect_o    (connect_pulse_o),
        .disconnect_o (disconnect_pulse_o)
    );

    usb_hc_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (cur_state == PORT_READY),
        .strobe_o (tick)
    );

    assign state_o        = cur_state;
    assign frame_strobe_o = tick & (cur_state == PORT_READY);

    // R10: the strobe is confined to Ready
    p_strobe_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe_o |-> (state_o == 2'd2));
    // R9: power enable is never granted outside host role
    p_vbus_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en || id_level) |=> !vbus_en_o);
endmodule

// File: tb/usb_host_conn_ctrl_bench.sv
module usb_host_conn_ctrl_bench;
    localparam int DEB = 4;
    localparam int FRM = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 0, id_level = 0, vbus_req = 0, dp_in = 0, dm_in = 0, sof_en = 0;
    logic [1:0] state_o;
    logic vbus_en_o, connect_pulse_o, disconnect_pulse_o, frame_strobe_o;

    always #10 clk = ~clk;

    usb_host_conn_ctrl #(.DEBOUNCE_CYCLES(DEB), .FRAME_CYCLES(FRM)) u_usb_host_conn_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .id_level(id_level),
        .vbus_req(vbus_req), .dp_in(dp_in), .dm_in(dm_in), .sof_en(sof_en),
        .state_o(state_o), .vbus_en_o(vbus_en_o), .connect_pulse_o(connect_pulse_o),
        .disconnect_pulse_o(disconnect_pulse_o), .frame_strobe_o(frame_strobe_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    logic [1:0] m_st;
    logic m_filt, m_vbus, m_conn, m_disc, m_strb;
    int m_dc, m_fc;

    function automatic logic [1:0] next_state(logic [1:0] s, logic host, logic att,
                                             logic vb, logic sof);
        if (!host) return 2'd0;
        case (s)
            2'd0: return 2'd1;
            2'd1: return (att && vb) ? 2'd2 : 2'd1;
            2'd2: return !att ? 2'd1 : (!sof ? 2'd3 : 2'd2);
            default: return !att ? 2'd1 : (sof ? 2'd2 : 2'd3);
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_filt = 0; m_vbus = 0; m_conn = 0; m_disc = 0; m_strb = 0;
        m_dc = 0; m_fc = 0;
    endtask

    task automatic model_step();
        logic host, raw, nf, nstrb;
        logic [1:0] ns;
        int ndc, nfc;
        host = ctl_en & ~id_level;
        raw = dp_in | dm_in;
        nf = m_filt; ndc = m_dc;
        if (raw == m_filt) ndc = 0;
        else if (m_dc == DEB - 1) begin nf = raw; ndc = 0; end
        else ndc = m_dc + 1;
        ns = next_state(m_st, host, m_filt, vbus_req, sof_en);
        nstrb = 0; nfc = m_fc;
        if (m_st != 2'd2) nfc = 0;
        else if (m_fc == FRM - 1) begin nfc = 0; nstrb = 1; end
        else nfc = m_fc + 1;
        m_conn = (m_st == 2'd1) && (ns == 2'd2);
        m_disc = host && (m_st == 2'd2 || m_st == 2'd3) && (ns == 2'd1);
        m_vbus = vbus_req & host;
        m_st = ns; m_filt = nf; m_dc = ndc; m_fc = nfc; m_strb = nstrb;
    endtask

    task automatic check1(string req, string what, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check1(tag, "state", state_o, m_st);
        check1("R8", "connect", {1'b0, connect_pulse_o}, {1'b0, m_conn});
        check1("R8", "disconnect", {1'b0, disconnect_pulse_o}, {1'b0, m_disc});
        check1("R9", "vbus_en", {1'b0, vbus_en_o}, {1'b0, m_vbus});
        check1("R10", "frame_strobe", {1'b0, frame_strobe_o},
               {1'b0, m_strb & (m_st == 2'd2)});
    endtask

    task automatic cyc(logic en, logic id, logic vb, logic p, logic m, logic sof, int n);
        for (int i = 0; i < n; i++) begin
            ctl_en = en; id_level = id; vbus_req = vb; dp_in = p; dm_in = m; sof_en = sof;
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        check1("R1", "reset state", state_o, 2'd0);
        check1("R1", "reset outputs",
               {1'b0, vbus_en_o | connect_pulse_o | disconnect_pulse_o | frame_strobe_o}, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        tag = "R2";  cyc(1, 0, 0, 0, 0, 1, 2);
        tag = "R5";  cyc(1, 0, 0, 1, 0, 1, 8);          // attached, no VBUS: stays Idle
        cyc(1, 0, 1, 1, 0, 1, 2);                       // VBUS given: Ready + connect
        tag = "R10"; cyc(1, 0, 1, 1, 0, 1, 25);
        tag = "R6";  cyc(1, 0, 1, 0, 1, 0, 3);
        tag = "R11";
        check1("R11", "suspend code", state_o, 2'd3);
        tag = "R6";  cyc(1, 0, 1, 0, 1, 1, 3);
        tag = "R4";  cyc(1, 0, 1, 0, 0, 1, 3);          // short glitch low
        cyc(1, 0, 1, 1, 1, 1, 4);
        check1("R4", "glitch ignored", state_o, 2'd2);
        tag = "R7";  cyc(1, 0, 1, 1, 0, 0, 2);          // to Suspend
        cyc(1, 0, 1, 0, 0, 0, 6);                       // detach from Suspend
        check1("R7", "back to idle", state_o, 2'd1);
        tag = "R3";  cyc(1, 0, 1, 1, 0, 1, 7);
        cyc(1, 1, 1, 1, 0, 1, 2);                       // leave host role
        cyc(1, 0, 1, 1, 0, 1, 3);
        cyc(0, 0, 1, 1, 0, 1, 2);                       // disable

        void'($urandom(32'd20240611));
        tag = "R7";
        begin
            logic p = 0, m = 0, sof = 1;
            for (int k = 0; k < 4000; k++) begin
                logic en, id, vb;
                en = ($urandom % 40) != 0;
                id = ($urandom % 60) == 0;
                vb = ($urandom % 10) != 0;
                if ($urandom % 9 == 0) begin p = $urandom; m = $urandom; end
                if ($urandom % 15 == 0) sof = ~sof;
                cyc(en, id, vb, p, m, sof, 1);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule